// File: doc/BRIEF.md
# Parallel NOR Flash Erase Command Interpreter

This block is the command front end of a parallel NOR flash device. It watches the host's write cycles, each one an address, a data byte and a write strobe. It recognises the six-cycle unlocked sequences that start a full-device erase or a single-sector erase. Once a sequence is accepted, it runs the erase by itself for a programmable number of clock cycles. The host supplies no further timing or control.

While an erase is in progress, incoming writes are filtered by fixed rules:

- A full-device erase cannot be interrupted.
- A sector erase accepts only a suspend request. Once suspended, it can later be resumed.

The block drives mode flags, a busy indicator and a one-hot mark of the sector being erased. It also tells the read path whether the current read address should return array contents or status. A short programming operation is modelled as a timed stub so that the suspend filtering can be exercised against it.

Top module: `nor_erase_ctrl`

## Requirements
- R1: After reset all mode flags, `busy`, `erase_marks` and `rd_status` are 0.
- R2: The full-device erase starts on the sixth of these consecutive accepted writes: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555. Addresses are compared on `wr_addr[11:0]`. `chip_busy` and `busy` are high from the cycle after that write, for exactly CHIP_CYC cycles.
- R3: A sector erase uses the same first five writes, followed by data 30 at any address. The sector index is `wr_addr[AW-1 -: log2(NSECT)]` of that sixth write. Bit `index` of `erase_marks` is set, and `sect_busy` and `busy` go high on the next cycle.
- R4: A write that breaks the expected sequence, or any write with data F0, returns the decoder to its first step and starts nothing.
- R5: During a full-device erase every write is ignored, including B0. No partial sequence is retained afterwards.
- R6: During an active sector erase every write other than B0 is ignored.
- R7: A B0 write during an active sector erase is accepted with any address. `susp_req` is high for exactly SUSP_LAT cycles, and then `susp_done` goes high and `busy` falls.
- R8: While suspended, `rd_status` is 1 when `rd_addr` falls in the marked sector and 0 otherwise. While busy, `rd_status` is 1 for any address.
- R9: While suspended, only a data-30 write (any address) is accepted; it resumes the erase. `sect_busy` is high for exactly SECT_CYC cycles in total across suspensions.
- R10: When an erase finishes, all flags fall, `erase_marks` clears and `rd_status` returns to 0 for every address.
- R11: The writes AA@555, 55@2AA, A0@555 followed by one more write start a program stub. `prog_busy` is high for PROG_CYC cycles, and a B0 written during it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Host write address |
| wr_data | input | 8 | Host write data / command byte |
| rd_addr | input | AW | Current host read address |
| busy | output | 1 | An embedded operation or suspend request is in progress |
| chip_busy | output | 1 | Full-device erase running |
| sect_busy | output | 1 | Sector erase actively running |
| susp_req | output | 1 | Suspend accepted, not yet complete |
| susp_done | output | 1 | Sector erase suspended |
| prog_busy | output | 1 | Program stub running |
| erase_marks | output | NSECT | One-hot mark of the sector under erase |
| rd_status | output | 1 | Read at `rd_addr` returns status instead of array data |

## Verification
Some properties are checked on every cycle:

- A full-device erase or a program stub can only continue or finish.
- An active sector erase leaves only toward suspension or completion.
- The suspended state is entered only through the suspend-request state.
- The erase mark is one-hot and empty whenever the engine is idle.
- A decoded start is followed by the matching mode flag and mark.

Only the bench scenarios can show the following:

- The exact durations.
- That ignored writes leave no trace in the decoder.
- The cumulative SECT_CYC budget across a suspend and resume.
- The address-dependent status selection for reads while suspended.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

   localparam logic [7:0]  CMD_UNLK_A  = 8'hAA;
   localparam logic [7:0]  CMD_UNLK_B  = 8'h55;
   localparam logic [7:0]  CMD_SETUP   = 8'h80;
   localparam logic [7:0]  CMD_CHIP    = 8'h10;
   localparam logic [7:0]  CMD_SECT    = 8'h30;
   localparam logic [7:0]  CMD_RESUME  = 8'h30;
   localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
   localparam logic [7:0]  CMD_PROG    = 8'hA0;
   localparam logic [7:0]  CMD_RESET   = 8'hF0;
   localparam logic [11:0] ADR_KEY_A   = 12'h555;
   localparam logic [11:0] ADR_KEY_B   = 12'h2AA;

   typedef enum logic [2:0] {
      DS_C1, DS_C2, DS_C3, DS_C4, DS_C5, DS_C6, DS_PGM
   } dec_step_t;

   typedef enum logic [2:0] {
      EN_IDLE, EN_CHIP, EN_SECT, EN_SPEND, EN_SUSP, EN_PROG
   } eng_st_t;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_erase_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   output logic          chip_go,
   output logic          sect_go,
   output logic          prog_go
);

   dec_step_t   step, step_nx;
   logic [11:0] a12;
   logic        key_a, key_b;

   assign a12   = wr_addr[11:0];
   assign key_a = (wr_data == CMD_UNLK_A) && (a12 == ADR_KEY_A);
   assign key_b = (wr_data == CMD_UNLK_B) && (a12 == ADR_KEY_B);

   always_comb begin
      step_nx = step;
      chip_go = 1'b0;
      sect_go = 1'b0;
      prog_go = 1'b0;
      if (!enable) begin
         step_nx = DS_C1;
      end else if (wr_en) begin
         if (wr_data == CMD_RESET) begin
            step_nx = DS_C1;
         end else begin
            unique case (step)
               DS_C1: step_nx = key_a ? DS_C2 : DS_C1;
               DS_C2: step_nx = key_b ? DS_C3 : DS_C1;
               DS_C3: begin
                  if (a12 == ADR_KEY_A && wr_data == CMD_SETUP)      step_nx = DS_C4;
                  else if (a12 == ADR_KEY_A && wr_data == CMD_PROG)  step_nx = DS_PGM;
                  else                                               step_nx = DS_C1;
               end
               DS_C4: step_nx = key_a ? DS_C5 : DS_C1;
               DS_C5: step_nx = key_b ? DS_C6 : DS_C1;
               DS_C6: begin
                  step_nx = DS_C1;
                  chip_go = (wr_data == CMD_CHIP) && (a12 == ADR_KEY_A);
                  sect_go = (wr_data == CMD_SECT);
               end
               DS_PGM: begin
                  step_nx = DS_C1;
                  prog_go = 1'b1;
               end
               default: step_nx = DS_C1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step <= DS_C1;
      else        step <= step_nx;
   end

   // R4: a reset code always lands the decoder on its first step
   a_r4_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_RESET) |=> (step == DS_C1));

   // R5: while the engine is busy the decoder does not advance
   a_r5_decoder_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (step == DS_C1));

endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine
   import nor_erase_pkg::*;
#(
   parameter int NSECT    = 8,
   parameter int SBW      = 3,
   parameter int CHIP_CYC = 4000,
   parameter int SECT_CYC = 1000,
   parameter int SUSP_LAT = 2000,
   parameter int PROG_CYC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             chip_go,
   input  logic             sect_go,
   input  logic             prog_go,
   input  logic [SBW-1:0]   go_sect,
   output eng_st_t          st,
   output logic [NSECT-1:0] marks
);

   localparam int MAX1 = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
   localparam int MAXC = (MAX1 > PROG_CYC) ? MAX1 : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int LW   = $clog2(SUSP_LAT + 1);

   logic [CW-1:0] cnt;
   logic [LW-1:0] pcnt;
   logic          wr_susp, wr_resume;

   assign wr_susp   = wr_en && (wr_data == CMD_SUSPEND);
   assign wr_resume = wr_en && (wr_data == CMD_RESUME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= EN_IDLE;
         cnt   <= '0;
         pcnt  <= '0;
         marks <= '0;
      end else begin
         unique case (st)
            EN_IDLE: begin
               if (chip_go) begin
                  st  <= EN_CHIP;
                  cnt <= CW'(CHIP_CYC - 1);
               end else if (sect_go) begin
                  st             <= EN_SECT;
                  cnt            <= CW'(SECT_CYC - 1);
                  marks[go_sect] <= 1'b1;
               end else if (prog_go) begin
                  st  <= EN_PROG;
                  cnt <= CW'(PROG_CYC - 1);
               end
            end
            EN_CHIP, EN_PROG: begin
               if (cnt == '0) st <= EN_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            EN_SECT: begin
               if (cnt == '0) begin
                  st    <= EN_IDLE;
                  marks <= '0;
               end else begin
                  cnt <= cnt - 1'b1;
                  if (wr_susp) begin
                     st   <= EN_SPEND;
                     pcnt <= LW'(SUSP_LAT - 1);
                  end
               end
            end
            EN_SPEND: begin
               if (pcnt == '0) st <= EN_SUSP;
               else            pcnt <= pcnt - 1'b1;
            end
            EN_SUSP: begin
               if (wr_resume) st <= EN_SECT;
            end
            default: st <= EN_IDLE;
         endcase
      end
   end

   // R5: full-device erase only continues or finishes
   a_r5_chip_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EN_CHIP) |=> (st == EN_CHIP || st == EN_IDLE));

   // R6: active sector erase leaves only toward suspension or completion
   a_r6_sect_exits: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EN_SECT) |=> (st == EN_SECT || st == EN_SPEND || st == EN_IDLE));

   // R7: suspension is reached only through the request state
   a_r7_via_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == EN_SUSP) |-> ($past(st) == EN_SPEND));

   // R11: program stub cannot be suspended
   a_r11_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EN_PROG) |=> (st == EN_PROG || st == EN_IDLE));

   // R3: at most one sector marked
   a_r3_onehot_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(marks));

   // R10: nothing marked while idle
   a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EN_IDLE) |-> (marks == '0));

endmodule

// File: rtl/nor_rd_sel.sv
module nor_rd_sel #(
   parameter int NSECT = 8,
   parameter int SBW   = 3
) (
   input  logic             busy,
   input  logic             susp_done,
   input  logic [NSECT-1:0] marks,
   input  logic [SBW-1:0]   rd_sect,
   output logic             rd_status
);

   logic hit;

   assign hit       = marks[rd_sect];
   assign rd_status = busy | (susp_done & hit);

endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
   import nor_erase_pkg::*;
#(
   parameter int AW       = 16,
   parameter int NSECT    = 8,
   parameter int CHIP_CYC = 4000,
   parameter int SECT_CYC = 1000,
   parameter int SUSP_LAT = 2000,   // 20 us at 100 MHz
   parameter int PROG_CYC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic             busy,
   output logic             chip_busy,
   output logic             sect_busy,
   output logic             susp_req,
   output logic             susp_done,
   output logic             prog_busy,
   output logic [NSECT-1:0] erase_marks,
   output logic             rd_status
);

   localparam int SB  = $clog2(NSECT);
   localparam int SBW = (SB == 0) ? 1 : SB;

   if (AW < 12)                      $error("AW must cover the 12-bit unlock keys");
   if (NSECT < 1)                    $error("NSECT must be at least 1");
   if ((NSECT & (NSECT - 1)) != 0)   $error("NSECT must be a power of two");
   if (SB > AW)                      $error("sector index wider than address");
   if (CHIP_CYC < 1 || SECT_CYC < 1 || PROG_CYC < 1 || SUSP_LAT < 1)
                                     $error("durations must be at least one cycle");

   logic [SBW-1:0] go_sect, rd_sect;

   if (SB == 0) begin : g_one_sector
      assign go_sect = '0;
      assign rd_sect = '0;
   end else begin : g_sliced
      assign go_sect = wr_addr[AW-1 -: SB];
      assign rd_sect = rd_addr[AW-1 -: SB];
   end

   logic    chip_go, sect_go, prog_go;
   eng_st_t st;

   nor_cmd_seq #(.AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (st == EN_IDLE),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .chip_go (chip_go),
      .sect_go (sect_go),
      .prog_go (prog_go)
   );

   nor_erase_engine #(
      .NSECT(NSECT), .SBW(SBW), .CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC),
      .SUSP_LAT(SUSP_LAT), .PROG_CYC(PROG_CYC)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .chip_go (chip_go),
      .sect_go (sect_go),
      .prog_go (prog_go),
      .go_sect (go_sect),
      .st      (st),
      .marks   (erase_marks)
   );

   assign chip_busy = (st == EN_CHIP);
   assign sect_busy = (st == EN_SECT);
   assign susp_req  = (st == EN_SPEND);
   assign susp_done = (st == EN_SUSP);
   assign prog_busy = (st == EN_PROG);
   assign busy      = chip_busy | sect_busy | susp_req | prog_busy;

   nor_rd_sel #(.NSECT(NSECT), .SBW(SBW)) u_rd (
      .busy      (busy),
      .susp_done (susp_done),
      .marks     (erase_marks),
      .rd_sect   (rd_sect),
      .rd_status (rd_status)
   );

   // R2: a decoded full-device start raises the chip flag next cycle
   a_r2_chip_start: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_go && st == EN_IDLE) |=> chip_busy);

   // R3: a decoded sector start marks exactly the addressed sector
   a_r3_sector_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_go && st == EN_IDLE) |=>
         (sect_busy && erase_marks == (NSECT'(1) << $past(go_sect))));

endmodule

// File: tb/sim_nor_erase_ctrl.sv
module sim_nor_erase_ctrl;

   localparam int AW = 16, NS = 8;
   localparam int CHIP_CYC = 20, SECT_CYC = 16, SUSP_LAT = 3, PROG_CYC = 5;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = 16'h4000;
   logic [7:0]    wr_data = '0;
   logic          busy, chip_busy, sect_busy, susp_req, susp_done, prog_busy, rd_status;
   logic [NS-1:0] erase_marks;

   always #2 clk = ~clk;   // 250 MHz

   nor_erase_ctrl #(.AW(AW), .NSECT(NS), .CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC),
                    .SUSP_LAT(SUSP_LAT), .PROG_CYC(PROG_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .busy(busy), .chip_busy(chip_busy), .sect_busy(sect_busy),
      .susp_req(susp_req), .susp_done(susp_done), .prog_busy(prog_busy),
      .erase_marks(erase_marks), .rd_status(rd_status));

   typedef struct { int cyc; logic [14:0] exp; string req; } item_t;
   item_t q[$];
   int cyc = 0, last_cap = 0, n_run = 0, n_fail = 0, sect_cnt = 0;

   wire [14:0] obs = {erase_marks, busy, chip_busy, sect_busy, susp_req,
                      susp_done, prog_busy, rd_status};

   function automatic logic [14:0] ob(logic [7:0] m, bit bz, bit ch, bit se,
                                      bit sr, bit sd, bit pg, bit rs);
      return {m, bz, ch, se, sr, sd, pg, rs};
   endfunction

   task automatic push(int at, logic [14:0] e, string r);
      item_t it;
      it.cyc = at; it.exp = e; it.req = r;
      q.push_back(it);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      last_cap = cyc + 2;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; wr_en = 1'b0; end
   endtask

   task automatic setrd(logic [AW-1:0] a, logic [14:0] e, string r);
      @(posedge clk); #1;
      wr_en = 1'b0; rd_addr = a;
      push(cyc + 1, e, r);
   endtask

   task automatic five_unlock();
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic direct(int act, int exp, string r);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   // monitor: pops scheduled expectations and compares at falling edges
   always @(negedge clk) begin
      cyc++;
      if (sect_busy) sect_cnt++;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         item_t it;
         it = q.pop_front();
         n_run++;
         if (it.cyc != cyc || obs !== it.exp) begin
            n_fail++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", it.req, it.cyc, obs, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   int c0, cs, p0;
   logic [14:0] chip_e, idle_e, sect_e, pend_e, prog_e;

   initial begin
      chip_e = ob(8'h00, 1, 1, 0, 0, 0, 0, 1);
      idle_e = ob(8'h00, 0, 0, 0, 0, 0, 0, 0);
      sect_e = ob(8'h20, 1, 0, 1, 0, 0, 0, 1);
      pend_e = ob(8'h20, 1, 0, 0, 1, 0, 0, 1);
      prog_e = ob(8'h00, 1, 0, 0, 0, 0, 1, 1);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      setrd(16'h4000, idle_e, "R1 reset state");

      // full-device erase, with writes that must be ignored
      five_unlock(); wr(16'h0555, 8'h10);
      c0 = last_cap;
      push(c0, chip_e, "R2 chip start");
      wr(16'h1234, 8'hB0);
      push(last_cap, chip_e, "R5 suspend ignored in chip erase");
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
      wr(16'hA123, 8'h30);
      push(last_cap, chip_e, "R5 sector cmd ignored in chip erase");
      idle(1);
      push(c0 + CHIP_CYC - 1, chip_e, "R2 chip duration last cycle");
      push(c0 + CHIP_CYC, idle_e, "R10 chip done");
      wait_idle();
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'hA123, 8'h30);
      push(last_cap, idle_e, "R5 no residue from ignored writes");
      idle(1);

      // aborted sequences
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h12); wr(16'h0555, 8'h10);
      push(last_cap, idle_e, "R4 mismatched cycle aborts");
      five_unlock(); wr(16'h0555, 8'hF0); wr(16'h0555, 8'h10);
      push(last_cap, idle_e, "R4 reset code aborts");
      idle(1);

      // sector erase on sector 5 with suspend / resume
      sect_cnt = 0;
      five_unlock(); wr(16'hA123, 8'h30);
      push(last_cap, sect_e, "R3 sector 5 marked");
      wr(16'h0000, 8'hF0);
      push(last_cap, sect_e, "R6 reset code ignored");
      wr(16'h0555, 8'h10); wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
      push(last_cap, sect_e, "R6 other writes ignored");
      wr(16'h1234, 8'hB0);
      cs = last_cap;
      push(cs, pend_e, "R7 suspend accepted");
      push(cs + SUSP_LAT - 1, pend_e, "R7 latency not yet elapsed");
      push(cs + SUSP_LAT, ob(8'h20, 0, 0, 0, 0, 1, 0, 0), "R7 suspended after latency");
      idle(SUSP_LAT + 2);
      setrd(16'hA000, ob(8'h20, 0, 0, 0, 0, 1, 0, 1), "R8 suspended sector gives status");
      setrd(16'h4000, ob(8'h20, 0, 0, 0, 0, 1, 0, 0), "R8 other sector gives data");
      wr(16'h0555, 8'hAA);
      push(last_cap, ob(8'h20, 0, 0, 0, 0, 1, 0, 0), "R9 non-resume ignored");
      wr(16'h0000, 8'h30);
      push(last_cap, sect_e, "R9 resume");
      idle(1);
      wait_idle();
      direct(sect_cnt, SECT_CYC, "R9 total active erase cycles");
      setrd(16'hA000, idle_e, "R10 sector done, marks cleared");

      // program stub
      wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h5A);
      p0 = last_cap;
      push(p0, prog_e, "R11 program start");
      wr(16'h0000, 8'hB0);
      push(last_cap, prog_e, "R11 suspend ignored in program");
      idle(1);
      push(p0 + PROG_CYC - 1, prog_e, "R11 program last cycle");
      push(p0 + PROG_CYC, ob(8'h00, 0, 0, 0, 0, 0, 0, 0), "R11 program done");
      wait_idle();

      // sector erase on sector 0, uninterrupted
      sect_cnt = 0;
      five_unlock(); wr(16'h0000, 8'h30);
      push(last_cap, ob(8'h01, 1, 0, 1, 0, 0, 0, 1), "R3 sector 0 marked");
      idle(1);
      wait_idle();
      direct(sect_cnt, SECT_CYC, "R3 sector erase duration");
      setrd(16'h0000, idle_e, "R10 sector 0 reads data");

      wait (q.size() == 0);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule